// File: doc/BRIEF.md
# Dual-Channel Converter Write-Cycle Sequencer

This block sits on the host side of a two-channel, double-buffered digital-to-analog converter. The converter has one shared parallel code bus, a channel-select line, an active-low write strobe and an active-low load strobe. Each channel has an input register, written by the write strobe, and an output register, loaded from the input register by the load strobe. The sequencer accepts one request. The request carries a code for each channel and an update mode. The sequencer then generates the bus waveforms needed to place both codes on the converter outputs.

Three update schedules are offered:

- **Two-write update:** the second write carries the load strobe, so both outputs change on that second write.
- **Three-step update:** both input registers are written first, and a separate load pulse follows.
- **Tied-strobe update:** the load line always mirrors the select line, as when the two pins share one wire. This forces channel B to be written first.

Every converter timing minimum is given in nanoseconds and converted to whole clock cycles by rounding up. The sequencer reports busy while it works and gives a one-cycle done pulse at the end.

Top module: `dacseq_top`

## Requirements
- R1: After reset, and in every cycle that `busy_o` is low, `wr_n_o` and `ld_n_o` are high; `busy_o` and `done_o` are low after reset.
- R2: Mode 0 (two-write), channel order and load strobe:
  - the first write goes to channel A (`sel_b_o` = 0) with `ld_n_o` high;
  - the second write goes to channel B (`sel_b_o` = 1) with `ld_n_o` low during the write;
  - both output registers hold their old codes at the first write's rising edge and both new codes at the second write's rising edge.
- R3: Mode 1 (three-step), and mode 3 which behaves the same:
  - both writes (A, then B) occur with `ld_n_o` high, and the outputs keep their old codes through both writes;
  - a standalone `ld_n_o` pulse with `wr_n_o` high then loads both new codes.
- R4: Mode 2 (tied strobe):
  - `ld_n_o` equals `sel_b_o` in every busy cycle;
  - the first write selects channel B and the second selects channel A;
  - both new codes are on the outputs once done.
- R5: `dbus_o` and `sel_b_o` never change while `wr_n_o` is low or in the cycle `wr_n_o` rises. Both are valid at least 220 ns and 150 ns, respectively, before each `wr_n_o` rising edge.
- R6: Every `wr_n_o` low pulse lasts at least 130 ns. Every standalone `ld_n_o` low pulse lasts at least 100 ns.
- R7: When `ld_n_o` is low at a `wr_n_o` rising edge, it went low at least 80 ns before that edge. It stays low at least 20 ns after it.
- R8: A request (`req_i` high) is accepted only while `busy_o` is low, and `busy_o` is high in the next cycle. A request made while busy is ignored and does not alter the codes delivered.
- R9: `done_o` is high for exactly one cycle. It rises in the cycle after the first cycle in which the final `ld_n_o` rise is visible, with both strobes high in that first cycle. `busy_o` is low whenever `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start request, sampled when not busy |
| mode_i | input | 2 | 0 two-write, 1 three-step, 2 tied strobe, 3 as 1 |
| code_a_i | input | 12 | Code for channel A |
| code_b_i | input | 12 | Code for channel B |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dbus_o | output | 12 | Converter code bus |
| sel_b_o | output | 1 | Channel select, 1 = channel B, 0 = channel A |
| wr_n_o | output | 1 | Active-low write strobe |
| ld_n_o | output | 1 | Active-low load strobe |

## Verification
Each mode is driven with extreme codes (all zeros against all ones), with alternating patterns, with codes either side of mid-scale, and with random codes. A model of the converter's four latches shows whether the outputs changed at the first write, at the second write or only at the separate load pulse, which tells the three schedules apart. Requests made mid-sequence with different codes show whether the busy gate holds. The edge-to-edge timing of every strobe pulse separates a correct sequence from one that is merely in the right order but too short.

// File: rtl/dacseq_pkg.sv
// Shared types and helpers for the converter write-cycle sequencer.
// Assumes all timing minimums are given in whole nanoseconds.
package dacseq_pkg;

    // Update schedule requested by the host
    typedef enum logic [1:0] {
        MODE_TWO   = 2'd0,
        MODE_THREE = 2'd1,
        MODE_TIED  = 2'd2,
        MODE_SPARE = 2'd3
    } upd_mode_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HOLD,
        ST_LPULSE,
        ST_FIN
    } seq_state_e;

    // Round a time up to whole clock cycles
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    // Larger of two counts
    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacseq_timer.sv
// Phase timer: a down-counter loaded with (length - 1) on entry to a
// phase; zero_o marks the last cycle of that phase.
// Assumes load_i is a single-cycle pulse from the sequencer.
module dacseq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dacseq_fsm.sv
// Sequencer: walks the write and load phases for the chosen mode and
// drives registered bus outputs, so no strobe can glitch.
// Assumes the phase lengths passed in already cover every minimum.
module dacseq_fsm
    import dacseq_pkg::*;
#(
    parameter int CODE_W   = 12,
    parameter int CNT_W    = 4,
    parameter int LOW_CYC  = 10,
    parameter int HOLD_CYC = 1,
    parameter int LP_CYC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic [CODE_W-1:0] code_a_i,
    input  logic [CODE_W-1:0] code_b_i,
    input  logic              tmr_zero_i,
    output logic              tmr_load_o,
    output logic [CNT_W-1:0]  tmr_val_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] dbus_o,
    output logic              sel_b_o,
    output logic              wr_n_o,
    output logic              ld_n_o
);

    localparam logic [CNT_W-1:0] LOW_M1  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_M1 = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LP_M1   = CNT_W'(LP_CYC - 1);

    seq_state_e        state_q;
    upd_mode_e         mode_q;
    logic              second_q;
    logic [CODE_W-1:0] a_q, b_q;
    logic              sep_load;

    // Three-step schedule (mode 3 aliases it) ends in a separate load pulse
    assign sep_load = (mode_q == MODE_THREE) || (mode_q == MODE_SPARE);

    // Timer loading at each phase entry
    always_comb begin
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        case (state_q)
            ST_SETUP: begin
                tmr_load_o = 1'b1;
                tmr_val_o  = LOW_M1;
            end
            ST_LOW: if (tmr_zero_i) begin
                tmr_load_o = 1'b1;
                tmr_val_o  = HOLD_M1;
            end
            ST_HOLD: if (tmr_zero_i && second_q && sep_load) begin
                tmr_load_o = 1'b1;
                tmr_val_o  = LP_M1;
            end
            default: ;
        endcase
    end

    // Phase sequencing and registered bus outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_TWO;
            second_q <= 1'b0;
            a_q      <= '0;
            b_q      <= '0;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            dbus_o   <= '0;
            sel_b_o  <= 1'b1;
            wr_n_o   <= 1'b1;
            ld_n_o   <= 1'b1;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_i) begin
                    mode_q   <= upd_mode_e'(mode_i);
                    a_q      <= code_a_i;
                    b_q      <= code_b_i;
                    busy_o   <= 1'b1;
                    second_q <= 1'b0;
                    state_q  <= ST_SETUP;
                    if (upd_mode_e'(mode_i) == MODE_TIED) begin
                        sel_b_o <= 1'b1;
                        dbus_o  <= code_b_i;
                        ld_n_o  <= 1'b1;
                    end else begin
                        sel_b_o <= 1'b0;
                        dbus_o  <= code_a_i;
                    end
                end
                ST_SETUP: begin
                    wr_n_o <= 1'b0;
                    if (second_q && mode_q == MODE_TWO)
                        ld_n_o <= 1'b0;
                    state_q <= ST_LOW;
                end
                ST_LOW: if (tmr_zero_i) begin
                    wr_n_o  <= 1'b1;
                    state_q <= ST_HOLD;
                end
                ST_HOLD: if (tmr_zero_i) begin
                    if (!second_q) begin
                        second_q <= 1'b1;
                        state_q  <= ST_SETUP;
                        if (mode_q == MODE_TIED) begin
                            sel_b_o <= 1'b0;
                            ld_n_o  <= 1'b0;
                            dbus_o  <= a_q;
                        end else begin
                            sel_b_o <= 1'b1;
                            dbus_o  <= b_q;
                        end
                    end else if (sep_load) begin
                        ld_n_o  <= 1'b0;
                        state_q <= ST_LPULSE;
                    end else begin
                        ld_n_o  <= 1'b1;
                        sel_b_o <= 1'b1;
                        state_q <= ST_FIN;
                    end
                end
                ST_LPULSE: if (tmr_zero_i) begin
                    ld_n_o  <= 1'b1;
                    state_q <= ST_FIN;
                end
                ST_FIN: begin
                    busy_o  <= 1'b0;
                    done_o  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dacseq_top.sv
// Top of the converter write-cycle sequencer. Converts each nanosecond
// minimum to clock cycles (rounded up) and sizes the three phase lengths:
// one write-low window long enough for every setup and width, one hold
// window after each write edge, and one standalone load pulse.
// Assumes a free-running clock of CLK_PERIOD_NS and a synchronous reset.
module dacseq_top
    import dacseq_pkg::*;
#(
    parameter int CODE_W        = 12,
    parameter int CLK_PERIOD_NS = 20,
    parameter int SEL_SETUP_NS  = 150,
    parameter int SEL_HOLD_NS   = 0,
    parameter int DATA_SETUP_NS = 220,
    parameter int DATA_HOLD_NS  = 0,
    parameter int WR_WIDTH_NS   = 130,
    parameter int LD_WIDTH_NS   = 100,
    parameter int LD_SETUP_NS   = 80,
    parameter int LD_HOLD_NS    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic [CODE_W-1:0] code_a_i,
    input  logic [CODE_W-1:0] code_b_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] dbus_o,
    output logic              sel_b_o,
    output logic              wr_n_o,
    output logic              ld_n_o
);

    localparam int SS_C = ns_to_cyc(SEL_SETUP_NS, CLK_PERIOD_NS);
    localparam int SH_C = ns_to_cyc(SEL_HOLD_NS, CLK_PERIOD_NS);
    localparam int DS_C = ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS);
    localparam int DH_C = ns_to_cyc(DATA_HOLD_NS, CLK_PERIOD_NS);
    localparam int WP_C = ns_to_cyc(WR_WIDTH_NS, CLK_PERIOD_NS);
    localparam int LP_C = ns_to_cyc(LD_WIDTH_NS, CLK_PERIOD_NS);
    localparam int LS_C = ns_to_cyc(LD_SETUP_NS, CLK_PERIOD_NS);
    localparam int LH_C = ns_to_cyc(LD_HOLD_NS, CLK_PERIOD_NS);

    // Bus values appear one setup cycle before the write strobe falls
    localparam int LOW_CYC  = max2(max2(max2(WP_C, LS_C), max2(DS_C, 1) - 1),
                                   max2(max2(SS_C, 1) - 1, 1));
    localparam int HOLD_CYC = max2(max2(LH_C, 1), max2(SH_C, DH_C));
    localparam int LP_CYC   = max2(LP_C, 1);
    localparam int MAX_CYC  = max2(LOW_CYC, max2(HOLD_CYC, LP_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    dacseq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    dacseq_fsm #(
        .CODE_W   (CODE_W),
        .CNT_W    (CNT_W),
        .LOW_CYC  (LOW_CYC),
        .HOLD_CYC (HOLD_CYC),
        .LP_CYC   (LP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .mode_i     (mode_i),
        .code_a_i   (code_a_i),
        .code_b_i   (code_b_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .dbus_o     (dbus_o),
        .sel_b_o    (sel_b_o),
        .wr_n_o     (wr_n_o),
        .ld_n_o     (ld_n_o)
    );

endmodule

// File: rtl/dacseq_chk.sv
// Protocol checker for the sequencer outputs, bound to dacseq_top.
// Assumes the same clock period and write-width minimum as the top.
module dacseq_chk #(
    parameter int CODE_W        = 12,
    parameter int CLK_PERIOD_NS = 20,
    parameter int WR_WIDTH_NS   = 130
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [CODE_W-1:0] dbus_o,
    input logic              sel_b_o,
    input logic              wr_n_o,
    input logic              ld_n_o
);

    localparam int WR_MIN = (WR_WIDTH_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    logic [7:0] low_run;

    // Count consecutive write-low cycles, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (!wr_n_o)
            low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
        else
            low_run <= '0;
    end

    assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (wr_n_o && ld_n_o));

    assert_bus_stable_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> ($stable(dbus_o) && $stable(sel_b_o)));

    assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> ($stable(dbus_o) && $stable(sel_b_o)));

    assert_wr_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> (low_run >= 8'(WR_MIN)));

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> busy_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

bind dacseq_top dacseq_chk #(
    .CODE_W        (CODE_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .WR_WIDTH_NS   (WR_WIDTH_NS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .dbus_o  (dbus_o),
    .sel_b_o (sel_b_o),
    .wr_n_o  (wr_n_o),
    .ld_n_o  (ld_n_o)
);

// File: tb/tb_dacseq_top.sv
`timescale 1ns/1ps
module tb_dacseq_top;

    localparam int P     = 20;
    localparam int T_SS  = 150;
    localparam int T_DS  = 220;
    localparam int T_WP  = 130;
    localparam int T_LP  = 100;
    localparam int T_LS  = 80;
    localparam int T_LH  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [11:0] code_a_i = '0, code_b_i = '0;
    logic        busy_o, done_o, sel_b_o, wr_n_o, ld_n_o;
    logic [11:0] dbus_o;

    int checks = 0;
    int errors = 0;

    dacseq_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .code_a_i(code_a_i), .code_b_i(code_b_i), .busy_o(busy_o),
        .done_o(done_o), .dbus_o(dbus_o), .sel_b_o(sel_b_o),
        .wr_n_o(wr_n_o), .ld_n_o(ld_n_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        if (m == 0) return "R2";
        if (m == 2) return "R4";
        return "R3";
    endfunction

    // Converter latch model and run context
    logic [11:0] m_in_a = '0, m_in_b = '0, m_dac_a = '0, m_dac_b = '0;
    logic [11:0] pre_a, pre_b, exp_a, exp_b;
    int          run_mode = 0;
    int          rise_idx = 0;
    int          tied_err = 0;
    int          done_cnt = 0;

    // Waveform history
    logic        p_wr = 1'b1, p_ld = 1'b1, p2_ld = 1'b1, p_done = 1'b0, p_sel = 1'b1;
    logic [11:0] p_dbus = '0;
    int d_age = 0, s_age = 0, wr_low = 0, ld_low = 0, since = 0;
    bit armed = 0;

    // Monitor: model the converter and measure every timing minimum
    always @(negedge clk) begin
        if (rst_n) begin
            if (!wr_n_o) begin
                if (sel_b_o) m_in_b = dbus_o; else m_in_a = dbus_o;
            end
            if (!ld_n_o) begin
                m_dac_a = m_in_a;
                m_dac_b = m_in_b;
            end
            d_age = (dbus_o == p_dbus) ? d_age + 1 : 1;
            s_age = (sel_b_o == p_sel) ? s_age + 1 : 1;
            if (armed) since++;

            if (!wr_n_o && !p_wr && (dbus_o != p_dbus || sel_b_o != p_sel))
                chk(0, "R5", "bus changed while write low", dbus_o, p_dbus);

            if (!p_wr && wr_n_o) begin
                chk(dbus_o == p_dbus && sel_b_o == p_sel, "R5", "bus hold at write rise",
                    dbus_o, p_dbus);
                chk((d_age - 1) * P >= T_DS, "R5", "data setup ns", (d_age - 1) * P, T_DS);
                chk((s_age - 1) * P >= T_SS, "R5", "select setup ns", (s_age - 1) * P, T_SS);
                chk(wr_low * P >= T_WP, "R6", "write width ns", wr_low * P, T_WP);
                if (!ld_n_o) begin
                    chk(ld_low * P >= T_LS, "R7", "load setup ns", ld_low * P, T_LS);
                    armed = 1;
                    since = 0;
                end
                rise_idx++;
                if (rise_idx == 1) begin
                    chk(sel_b_o == (run_mode == 2), mode_tag(run_mode), "first channel",
                        sel_b_o, run_mode == 2);
                    chk(m_dac_a == pre_a && m_dac_b == pre_b, mode_tag(run_mode),
                        "outputs after first write", m_dac_a, pre_a);
                end else if (rise_idx == 2) begin
                    if (run_mode == 0 || run_mode == 2)
                        chk(m_dac_a == exp_a && m_dac_b == exp_b, mode_tag(run_mode),
                            "outputs after second write", m_dac_b, exp_b);
                    else
                        chk(m_dac_a == pre_a && m_dac_b == pre_b, "R3",
                            "outputs before load pulse", m_dac_b, pre_b);
                end
            end

            if (!p_ld && ld_n_o) begin
                if (armed) begin
                    chk(since * P >= T_LH, "R7", "load hold ns", since * P, T_LH);
                    armed = 0;
                end else begin
                    chk(ld_low * P >= T_LP, "R6", "load pulse ns", ld_low * P, T_LP);
                end
            end

            if (busy_o && run_mode == 2 && ld_n_o != sel_b_o) tied_err++;

            if (done_o) begin
                chk(!p_done, "R9", "done width", p_done, 0);
                chk(p_wr && p_ld && !p2_ld, "R9", "done placement", {p2_ld, p_ld}, 1);
                done_cnt++;
            end

            wr_low = !wr_n_o ? wr_low + 1 : 0;
            ld_low = !ld_n_o ? ld_low + 1 : 0;
            p2_ld  = p_ld;
            p_ld   = ld_n_o;
            p_wr   = wr_n_o;
            p_sel  = sel_b_o;
            p_dbus = dbus_o;
            p_done = done_o;
        end
    end

    task automatic run(input int m, input logic [11:0] a, input logic [11:0] b,
                       input bit poke);
        int waited;
        pre_a    = m_dac_a;
        pre_b    = m_dac_b;
        exp_a    = a;
        exp_b    = b;
        run_mode = (m == 3) ? 1 : m;
        rise_idx = 0;
        tied_err = 0;
        mode_i   = 2'(m);
        code_a_i = a;
        code_b_i = b;
        req_i    = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        chk(busy_o == 1'b1, "R8", "busy after request", busy_o, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            mode_i   = 2'(m ^ 1);
            code_a_i = ~a;
            code_b_i = ~b;
            req_i    = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 400, "R9", "done reached", waited, 400);
        repeat (2) @(negedge clk);
        chk(m_dac_a == a, mode_tag(run_mode), "final code A", m_dac_a, a);
        chk(m_dac_b == b, mode_tag(run_mode), "final code B", m_dac_b, b);
        chk(busy_o == 1'b0, "R8", "idle after done", busy_o, 0);
        if (m == 2) chk(tied_err == 0, "R4", "load mirrors select", tied_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_n_o && ld_n_o, "R1", "strobes high in reset", {wr_n_o, ld_n_o}, 3);
        chk(!busy_o && !done_o, "R1", "busy/done low in reset", {busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_n_o && ld_n_o && !busy_o, "R1", "idle after reset",
            {wr_n_o, ld_n_o, busy_o}, 6);

        run(0, 12'hFFF, 12'h000, 0);
        run(1, 12'h000, 12'hFFF, 0);
        run(2, 12'hA5A, 12'h5A5, 0);
        run(3, 12'h800, 12'h7FF, 0);
        run(0, 12'h7FF, 12'h800, 1);
        run(2, 12'h001, 12'hFFE, 1);
        run(1, 12'h555, 12'hAAA, 1);

        void'($urandom(32'd2024));
        for (int i = 0; i < 40; i++) begin
            run(int'($urandom % 4), 12'($urandom), 12'($urandom), ($urandom % 5) == 0);
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        chk(done_cnt == 47, "R9", "done pulse count", done_cnt, 47);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule